// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block runs once after each reset and brings an asynchronous DRAM to a usable state. It first holds both strobes inactive for a power-up pause. It then issues a fixed number of refresh cycles, separated by RAS precharge, and finally raises a ready flag that stays high until the next reset.

Two cycle types are supported. The first is a row-only refresh: RAS goes low with CAS held high, and a row address is driven that steps by one per cycle. The second is a CAS-before-RAS refresh: CAS goes low ahead of RAS, stays low while RAS is low, and is released after RAS. The second type must be chosen whenever the system will later rely on the DRAM's internal refresh counter.

The pause requested at the input is never allowed below a parameterised floor. The default floor is 20000 clocks, which is 100 µs at 200 MHz. The mode select and the pause length are captured while reset is asserted.

Top module: `dram_init_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n` = 1, `cas_n` = 1, `ready` = 0, `busy` = 1 and `row_addr` = 0.
- R2: The pause lasts P = max(`pause_clks`, MIN_PAUSE) clocks, counted from the last clock edge with `rst_n` low. During the pause both strobes are high and `row_addr` = 0.
- R3: Exactly N_INIT refresh cycles are issued after the pause. N_INIT defaults to 8 and must be at least 8.
- R4: With `use_cbr` = 0 (row-only mode), each cycle holds `ras_n` low for RAS_ACT clocks with `cas_n` high. `row_addr` equals the cycle index k (0-based) from the start of cycle k until the start of cycle k+1. After the last cycle it reads N_INIT.
- R5: With `use_cbr` = 1, each cycle drives `cas_n` low for CAS_LEAD clocks with `ras_n` high. Next, both strobes are low for RAS_ACT clocks. Then `ras_n` is high with `cas_n` low for CAS_HOLD clocks. `row_addr` stays 0 throughout.
- R6: Every cycle, including the last, ends with PRECH clocks in which both strobes are high.
- R7: `ready` rises on the first clock after the last precharge and stays high until reset. `busy` is always the inverse of `ready`.
- R8: `use_cbr` and `pause_clks` are sampled only while `rst_n` is low. Changing them after reset release has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pause_clks | input | PAUSE_W | Requested power-up pause in clocks |
| use_cbr | input | 1 | 1 = CAS-before-RAS cycles, 0 = row-only cycles |
| ras_n | output | 1 | Row strobe, active low, registered |
| cas_n | output | 1 | Column strobe, active low, registered |
| row_addr | output | ROW_W | Row address for row-only cycles |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Initialization complete |

## Verification
The bench sweeps both modes against requested pauses below, at, one above and well above the floor. It compares every clock of the strobe, address and ready waveform with a timeline computed arithmetically in the bench.

A design that ignored the floor would start refreshing too early. An off-by-one timer would stretch or shrink each phase by one clock. A cycle counter that tested the wrong terminal value would issue seven or nine cycles, and the bench counts RAS falling edges to catch this.

A design that released CAS together with RAS, or that raised `ready` before the final precharge, would differ on a single clock, and the per-clock compare catches that. Both inputs are flipped right after reset release, which exposes a design that samples them live.

// File: rtl/dram_init_pkg.sv
// Shared state encoding for the DRAM start-up sequencer.
// Assumes nothing beyond a 3-bit state register.
package dram_init_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE = 3'd0,
        ST_CLEAD = 3'd1,
        ST_ACT   = 3'd2,
        ST_CHOLD = 3'd3,
        ST_PRE   = 3'd4,
        ST_DONE  = 3'd5
    } init_st_e;
endpackage

// File: rtl/dram_init_timer.sv
// Loadable down-counter that times every phase of the sequencer.
// Assumes each load value is the phase length minus one, and that the
// reset value is presented while rst_n is low.
module dram_init_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] rst_val,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    // Count down to zero, reload on request or during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= rst_val;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/dram_init_cnt.sv
// Counts completed initialization cycles, which doubles as the row index.
// Assumes the controller increments at most N_INIT times after reset.
module dram_init_cnt #(
    parameter int N_INIT = 8,
    parameter int CW     = $clog2(N_INIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          last
);
    // Advance by one at the end of each precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(N_INIT - 1));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(N_INIT));
endmodule

// File: rtl/dram_init_seq.sv
// Top of the DRAM start-up sequencer: pause, N_INIT refresh cycles, ready.
// Assumes all phase lengths are at least one clock, the floor pause fits in
// PAUSE_W bits, and that the inputs are steady while rst_n is low.
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int PAUSE_W   = 16,
    parameter int MIN_PAUSE = 20000,
    parameter int N_INIT    = 8,
    parameter int RAS_ACT   = 3,
    parameter int PRECH     = 2,
    parameter int CAS_LEAD  = 1,
    parameter int CAS_HOLD  = 1,
    parameter int ROW_W     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAUSE_W-1:0] pause_clks,
    input  logic               use_cbr,
    output logic               ras_n,
    output logic               cas_n,
    output logic [ROW_W-1:0]   row_addr,
    output logic               busy,
    output logic               ready
);
    localparam int CW = $clog2(N_INIT + 1);
    localparam logic [PAUSE_W-1:0] FLOOR_V = PAUSE_W'(MIN_PAUSE);
    localparam logic [PAUSE_W-1:0] LD_LEAD = PAUSE_W'(CAS_LEAD - 1);
    localparam logic [PAUSE_W-1:0] LD_ACT  = PAUSE_W'(RAS_ACT - 1);
    localparam logic [PAUSE_W-1:0] LD_HOLD = PAUSE_W'(CAS_HOLD - 1);
    localparam logic [PAUSE_W-1:0] LD_PRE  = PAUSE_W'(PRECH - 1);

    init_st_e           state_q, state_d;
    logic               mode_q;
    logic               ld, tmr_zero, inc, last;
    logic [PAUSE_W-1:0] ld_val, pause_ld;
    logic [CW-1:0]      cyc;
    logic               ras_q, cas_q, rdy_q;

    // Clamp the requested pause to the floor; used only during reset.
    always_comb begin
        pause_ld = ((pause_clks < FLOOR_V) ? FLOOR_V : pause_clks) - 1'b1;
    end

    dram_init_timer #(.TW(PAUSE_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .rst_val(pause_ld),
        .load(ld), .load_val(ld_val), .zero(tmr_zero)
    );

    dram_init_cnt #(.N_INIT(N_INIT), .CW(CW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .inc(inc), .cnt(cyc), .last(last)
    );

    // Next-state and timer-load decode for the phase sequence.
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = LD_ACT;
        inc     = 1'b0;
        case (state_q)
            ST_PAUSE: if (tmr_zero) begin
                ld = 1'b1;
                if (mode_q) begin state_d = ST_CLEAD; ld_val = LD_LEAD; end
                else        begin state_d = ST_ACT;   ld_val = LD_ACT;  end
            end
            ST_CLEAD: if (tmr_zero) begin
                ld = 1'b1; state_d = ST_ACT; ld_val = LD_ACT;
            end
            ST_ACT: if (tmr_zero) begin
                ld = 1'b1;
                if (mode_q) begin state_d = ST_CHOLD; ld_val = LD_HOLD; end
                else        begin state_d = ST_PRE;   ld_val = LD_PRE;  end
            end
            ST_CHOLD: if (tmr_zero) begin
                ld = 1'b1; state_d = ST_PRE; ld_val = LD_PRE;
            end
            ST_PRE: if (tmr_zero) begin
                inc = 1'b1;
                if (last) state_d = ST_DONE;
                else begin
                    ld = 1'b1;
                    if (mode_q) begin state_d = ST_CLEAD; ld_val = LD_LEAD; end
                    else        begin state_d = ST_ACT;   ld_val = LD_ACT;  end
                end
            end
            default: state_d = ST_DONE;
        endcase
    end

    // State, captured mode and glitch-free registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
            mode_q  <= use_cbr;
            ras_q   <= 1'b1;
            cas_q   <= 1'b1;
            rdy_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ras_q   <= !(state_d == ST_ACT);
            cas_q   <= !(mode_q && (state_d == ST_CLEAD || state_d == ST_ACT ||
                                    state_d == ST_CHOLD));
            rdy_q   <= (state_d == ST_DONE);
        end
    end

    assign ras_n    = ras_q;
    assign cas_n    = cas_q;
    assign ready    = rdy_q;
    assign busy     = !rdy_q;
    assign row_addr = mode_q ? '0 : ROW_W'(cyc);

    // R4
    ras_only_cas_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> cas_n);
    // R5
    cbr_cas_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !ras_n) |-> !cas_n);
    // R2
    pause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE) |-> (ras_n && cas_n));
    // R6
    ras_prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);
    // R7
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    // R7
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ras_n && cas_n));
endmodule

// File: tb/dram_init_seq_tb.sv
module dram_init_seq_tb_top;
    localparam int PW = 8, MINP = 6, N = 8, RA = 3, PR = 2, CL = 1, CH = 1, RW = 4;

    logic clk = 1'b0, rst_n = 1'b0, use_cbr = 1'b0;
    logic [PW-1:0] pause_clks = '0;
    logic ras_n, cas_n, busy, ready;
    logic [RW-1:0] row_addr;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dram_init_seq #(.PAUSE_W(PW), .MIN_PAUSE(MINP), .N_INIT(N), .RAS_ACT(RA),
        .PRECH(PR), .CAS_LEAD(CL), .CAS_HOLD(CH), .ROW_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pause_clks(pause_clks), .use_cbr(use_cbr),
        .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr), .busy(busy), .ready(ready));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected {ras,cas,row,ready} and phase tag at sample s after reset.
    task automatic expect_at(input bit m, input int p, input int s,
                             output int er, output int ec, output int ea,
                             output int ey, output string tag);
        int len, t, k, o, act_start;
        er = 1; ec = 1; ea = 0; ey = 0; tag = "R2";
        if (s < p) return;
        len = (m ? CL + RA + CH : RA) + PR;
        t = s - p; k = t / len; o = t % len;
        if (k >= N) begin ey = 1; ea = m ? 0 : N; tag = "R7"; return; end
        ea = m ? 0 : k;
        act_start = m ? CL : 0;
        if (o < act_start) begin ec = 0; tag = "R5"; end
        else if (o < act_start + RA) begin er = 0; ec = m ? 0 : 1; tag = m ? "R5" : "R4"; end
        else if (m && o < act_start + RA + CH) begin ec = 0; tag = "R5"; end
        else tag = "R6";
    endtask

    task automatic run(input bit m, input int preq);
        int p, total, falls, er, ec, ea, ey;
        logic prev_ras;
        string tag;
        p = (preq < MINP) ? MINP : preq;
        total = p + N * ((m ? CL + RA + CH : RA) + PR);
        rst_n = 1'b0; use_cbr = m; pause_clks = PW'(preq);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ras_n", int'(ras_n), 1); chk("R1 cas_n", int'(cas_n), 1);
        chk("R1 ready", int'(ready), 0); chk("R1 busy", int'(busy), 1);
        chk("R1 row", int'(row_addr), 0);
        rst_n = 1'b1;
        use_cbr = !m; pause_clks = PW'(preq + 40);   // R8: must not matter
        falls = 0; prev_ras = 1'b1;
        for (int s = 0; s < total + 12; s++) begin
            if (s > 0) @(negedge clk);
            expect_at(m, p, s, er, ec, ea, ey, tag);
            chk({tag, " R8 ras_n"}, int'(ras_n), er);
            chk({tag, " R8 cas_n"}, int'(cas_n), ec);
            chk({tag, " row_addr"}, int'(row_addr), ea);
            chk({tag, " ready"}, int'(ready), ey);
            chk("R7 busy", int'(busy), 1 - ey);
            if (prev_ras && !ras_n) falls++;
            prev_ras = ras_n;
        end
        chk("R3 cycle count", falls, N);
    endtask

    initial begin
        int pl[5] = '{0, 3, 6, 7, 12};
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 5; i++)
                run(m[0], pl[i]);
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule